// File: doc/BRIEF.md
# Carrier Recovery Loop Filter with Limited, Swept Integrator

This block is the loop filter of a second-order carrier-recovery phase-locked loop. On every loop-update strobe it takes a signed phase-error sample and a signed frequency-error sample. It forms a proportional term and an integrator ("lag") term. It then registers a frequency-correction word for the oscillator that follows. All gains are arithmetic right shifts, so the datapath has no multiplier.

The integrator saturates between two programmable signed limits in both acquisition and tracking. While acquiring, the loop runs as first order and a sweep step is added to the integrator. The sweep is added on every update, or only on updates flagged by a lock-detector timeout pulse. A two-state machine holds the sweep direction. In state S_UP the step is added. In state S_DOWN it is subtracted. Transition T_TOP (S_UP to S_DOWN) fires when a swept update reaches the upper limit. Transition T_FLOOR (S_DOWN to S_UP) fires when a swept update reaches the lower limit. Transition T_CLR forces S_UP on clear or reset. A frequency-error term with separate acquisition and tracking shifts can also be summed into the integrator.

Top module: `carrier_loop_filter`

## Requirements
- R1: `order` = 0 freezes the integrator and drives `freq_out` to 0 on an update. `order` = 1 keeps the phase error out of the integrator. `order` = 2 or 3 runs the full proportional-plus-integral filter.
- R2: After every update the integrator value `lag_out` lies in the signed range [`lim_lo`, `lim_hi`] and saturates there rather than wrapping.
- R3: The proportional term is `phase_err >>> lead_shift` and the integral input is `phase_err >>> lag_shift`. Both are arithmetic shifts of the sign-extended sample.
- R4: While `acquire` = 1 with `stepped` = 0, each update adds `+sweep_step` in S_UP or `-sweep_step` in S_DOWN to the integrator.
- R5: T_TOP fires when the unclamped swept sum is >= `lim_hi` in S_UP. T_FLOOR fires when it is <= `lim_lo` in S_DOWN. Otherwise the direction holds.
- R6: Without `upd` and without `clr`, `lag_out` and `freq_out` hold their values.
- R7: While `acquire` = 1, orders 2 and 3 behave as order 1. Order 0 still freezes the loop.
- R8: With `stepped` = 1, the sweep is applied (and can reverse) only on updates where `step_tick` = 1.
- R9: With `afc_en` = 1, `freq_err >>> afc_shift_acq` (acquiring) or `freq_err >>> afc_shift_trk` (tracking) is added to the integrator. With `afc_en` = 0 nothing is added.
- R10: On the clock edge of an update, `freq_out` becomes the proportional term plus the new integrator value, saturated to the signed `AW`-bit range.
- R11: `clr` is synchronous and overrides `upd`. It sets the integrator and output to 0 and selects S_UP.
- R12: After reset, `lag_out` and `freq_out` are 0 and the sweep state is S_UP.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clr | input | 1 | Synchronous clear |
| upd | input | 1 | Loop-update strobe |
| phase_err | input | EW | Signed phase-error sample |
| freq_err | input | EW | Signed frequency-error sample |
| lead_shift | input | SHW | Proportional gain shift |
| lag_shift | input | SHW | Integral gain shift |
| afc_shift_acq | input | SHW | Frequency-error gain shift while acquiring |
| afc_shift_trk | input | SHW | Frequency-error gain shift while tracking |
| afc_en | input | 1 | Enables the frequency-error term |
| lim_hi | input | AW | Signed upper integrator limit |
| lim_lo | input | AW | Signed lower integrator limit |
| sweep_step | input | AW | Unsigned sweep increment |
| order | input | 2 | Loop order select |
| acquire | input | 1 | 1 = acquisition, 0 = tracking |
| stepped | input | 1 | 1 = sweep only on `step_tick` |
| step_tick | input | 1 | Lock-detector timeout pulse |
| freq_out | output | AW | Signed frequency-correction word |
| lag_out | output | AW | Signed integrator value |

## Verification
The limit assertion assumes `lim_lo` <= `lim_hi` and is gated on that condition. Every stimulus phase keeps the lower limit at or below zero and the upper limit at or above it. The sum-width headroom assumes the limits and the sweep step stay within the `AW`-bit range. The bench never drives a step larger than the limit span. The bench holds the limits constant around each update, so the sampled bounds match those used by the design. A behavioural reference model with plain integers predicts both outputs and is compared on every clock.

// File: rtl/clf_pkg.sv
package clf_pkg;
    typedef enum logic [0:0] {S_UP = 1'b0, S_DOWN = 1'b1} sweep_st_t;

    // effective loop order: 0 off, 1 first order, 2 full filter
    function automatic logic [1:0] eff_order(input logic [1:0] ord, input logic acq);
        if (ord == 2'd0)                 return 2'd0;
        else if (ord == 2'd1 || acq)     return 2'd1;
        else                             return 2'd2;
    endfunction
endpackage

// File: rtl/clf_shift_gain.sv
module clf_shift_gain #(
    parameter int IW  = 12,
    parameter int OW  = 26,
    parameter int SHW = 5
) (
    input  logic signed [IW-1:0]  in_val,
    input  logic        [SHW-1:0] sh,
    output logic signed [OW-1:0]  out_val
);
    logic signed [OW-1:0] ext;
    assign ext     = {{(OW-IW){in_val[IW-1]}}, in_val};
    assign out_val = ext >>> sh;
endmodule

// File: rtl/clf_sat.sv
module clf_sat #(
    parameter int IW = 26,
    parameter int OW = 24
) (
    input  logic signed [IW-1:0] val,
    input  logic signed [OW-1:0] lo,
    input  logic signed [OW-1:0] hi,
    output logic signed [OW-1:0] res,
    output logic                 at_hi,
    output logic                 at_lo
);
    logic signed [IW-1:0] lo_x, hi_x;
    assign lo_x = {{(IW-OW){lo[OW-1]}}, lo};
    assign hi_x = {{(IW-OW){hi[OW-1]}}, hi};

    always_comb begin
        at_hi = (val >= hi_x);
        at_lo = (val <= lo_x);
        if (val > hi_x)      res = hi;
        else if (val < lo_x) res = lo;
        else                 res = val[OW-1:0];
    end
endmodule

// File: rtl/carrier_loop_filter.sv
module carrier_loop_filter
    import clf_pkg::*;
#(
    parameter int EW  = 12,
    parameter int AW  = 24,
    parameter int SHW = 5
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 clr,
    input  logic                 upd,
    input  logic signed [EW-1:0] phase_err,
    input  logic signed [EW-1:0] freq_err,
    input  logic [SHW-1:0]       lead_shift,
    input  logic [SHW-1:0]       lag_shift,
    input  logic [SHW-1:0]       afc_shift_acq,
    input  logic [SHW-1:0]       afc_shift_trk,
    input  logic                 afc_en,
    input  logic signed [AW-1:0] lim_hi,
    input  logic signed [AW-1:0] lim_lo,
    input  logic [AW-1:0]        sweep_step,
    input  logic [1:0]           order,
    input  logic                 acquire,
    input  logic                 stepped,
    input  logic                 step_tick,
    output logic signed [AW-1:0] freq_out,
    output logic signed [AW-1:0] lag_out
);
    localparam int SW = AW + 2;
    localparam logic signed [AW-1:0] OUT_MAX = {1'b0, {(AW-1){1'b1}}};
    localparam logic signed [AW-1:0] OUT_MIN = {1'b1, {(AW-1){1'b0}}};

    sweep_st_t st_q, st_d;
    logic signed [AW-1:0] lag_q, out_q;
    logic [1:0]           eo;
    logic [SHW-1:0]       afc_sh;
    logic signed [SW-1:0] lead_raw, lag_raw, afc_raw;
    logic signed [SW-1:0] lead_t, lag_t, afc_t, sweep_t, step_x, lag_sum, out_sum;
    logic signed [AW-1:0] lag_next, out_next;
    logic                 sweep_on, hit_hi, hit_lo, o_hi, o_lo;

    assign eo     = eff_order(order, acquire);
    assign afc_sh = acquire ? afc_shift_acq : afc_shift_trk;

    clf_shift_gain #(.IW(EW), .OW(SW), .SHW(SHW)) i_lead (
        .in_val(phase_err), .sh(lead_shift), .out_val(lead_raw));
    clf_shift_gain #(.IW(EW), .OW(SW), .SHW(SHW)) i_lag (
        .in_val(phase_err), .sh(lag_shift), .out_val(lag_raw));
    clf_shift_gain #(.IW(EW), .OW(SW), .SHW(SHW)) i_afc (
        .in_val(freq_err), .sh(afc_sh), .out_val(afc_raw));

    always_comb begin
        step_x   = {2'b00, sweep_step};
        sweep_on = acquire && (eo != 2'd0) && (!stepped || step_tick);
        lead_t   = (eo != 2'd0) ? lead_raw : '0;
        lag_t    = (eo == 2'd2) ? lag_raw : '0;
        afc_t    = afc_en ? afc_raw : '0;
        if (!sweep_on)        sweep_t = '0;
        else if (st_q == S_UP) sweep_t = step_x;
        else                   sweep_t = -step_x;
        lag_sum  = {{2{lag_q[AW-1]}}, lag_q} + lag_t + afc_t + sweep_t;
    end

    clf_sat #(.IW(SW), .OW(AW)) i_lag_sat (
        .val(lag_sum), .lo(lim_lo), .hi(lim_hi),
        .res(lag_next), .at_hi(hit_hi), .at_lo(hit_lo));

    assign out_sum = lead_t + {{2{lag_next[AW-1]}}, lag_next};

    clf_sat #(.IW(SW), .OW(AW)) i_out_sat (
        .val(out_sum), .lo(OUT_MIN), .hi(OUT_MAX),
        .res(out_next), .at_hi(o_hi), .at_lo(o_lo));

    // sweep direction next-state logic
    always_comb begin
        st_d = st_q;
        if (clr) begin
            st_d = S_UP;                                   // T_CLR
        end else if (upd && sweep_on) begin
            unique case (st_q)
                S_UP:   if (hit_hi) st_d = S_DOWN;         // T_TOP
                S_DOWN: if (hit_lo) st_d = S_UP;           // T_FLOOR
                default: st_d = S_UP;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= S_UP;
        else        st_q <= st_d;
    end

    // datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lag_q <= '0;
            out_q <= '0;
        end else if (clr) begin
            lag_q <= '0;
            out_q <= '0;
        end else if (upd) begin
            if (eo == 2'd0) begin
                out_q <= '0;
            end else begin
                lag_q <= lag_next;
                out_q <= out_next;
            end
        end
    end

    assign freq_out = out_q;
    assign lag_out  = lag_q;

    a_r2_lag_in_limits: assert property (@(posedge clk) disable iff (!rst_n)
        (upd && !clr && order != 2'd0 && lim_lo <= lim_hi)
        |=> (lag_q >= $past(lim_lo) && lag_q <= $past(lim_hi)));

    a_r1_order_zero_off: assert property (@(posedge clk) disable iff (!rst_n)
        (upd && !clr && order == 2'd0) |=> (out_q == '0 && $stable(lag_q)));

    a_r6_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!upd && !clr) |=> ($stable(lag_q) && $stable(out_q)));

    a_r11_clear: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (lag_q == '0 && out_q == '0 && st_q == S_UP));

    a_r5_dir_only_sweeping: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && !(upd && acquire)) |=> $stable(st_q));
endmodule

// File: tb/test_carrier_loop_filter.sv
module test_carrier_loop_filter;
    localparam int EW = 12, AW = 24, SHW = 5;

    logic clk = 1'b0, rst_n = 1'b0, clr = 1'b0, upd = 1'b0;
    logic signed [EW-1:0] phase_err = '0, freq_err = '0;
    logic [SHW-1:0] lead_shift = '0, lag_shift = '0, afc_shift_acq = '0, afc_shift_trk = '0;
    logic afc_en = 1'b0, acquire = 1'b0, stepped = 1'b0, step_tick = 1'b0;
    logic signed [AW-1:0] lim_hi = '0, lim_lo = '0;
    logic [AW-1:0] sweep_step = '0;
    logic [1:0] order = 2'd2;
    logic signed [AW-1:0] freq_out, lag_out;

    int n_cmp = 0, n_bad = 0, cyc = 0;
    bit done = 0;
    longint m_lag = 0, m_out = 0;
    int m_up = 1;
    int flips = 0;

    carrier_loop_filter #(.EW(EW), .AW(AW), .SHW(SHW)) i_carrier_loop_filter (
        .clk, .rst_n, .clr, .upd, .phase_err, .freq_err, .lead_shift, .lag_shift,
        .afc_shift_acq, .afc_shift_trk, .afc_en, .lim_hi, .lim_lo, .sweep_step,
        .order, .acquire, .stepped, .step_tick, .freq_out, .lag_out);

    always #5 clk = ~clk;

    function automatic longint clampl(longint v, longint lo, longint hi);
        if (v > hi) return hi;
        if (v < lo) return lo;
        return v;
    endfunction

    // behavioural reference for one clock edge
    task automatic model_edge();
        longint pe, fe, lead, sum, stp;
        int eo;
        bit sw;
        pe = longint'(phase_err);
        fe = longint'(freq_err);
        if (clr) begin
            m_lag = 0; m_out = 0; m_up = 1;
            return;
        end
        if (!upd) return;
        eo = (order == 0) ? 0 : ((order == 1 || acquire) ? 1 : 2);
        if (eo == 0) begin m_out = 0; return; end
        lead = pe >>> lead_shift;
        sum  = m_lag;
        if (eo == 2) sum += pe >>> lag_shift;
        if (afc_en)  sum += fe >>> (acquire ? afc_shift_acq : afc_shift_trk);
        sw  = acquire && (!stepped || step_tick);
        stp = longint'(sweep_step);
        if (sw) sum += (m_up != 0) ? stp : -stp;
        if (sw && m_up != 0 && sum >= longint'(lim_hi)) begin m_up = 0; flips++; end
        else if (sw && m_up == 0 && sum <= longint'(lim_lo)) begin m_up = 1; flips++; end
        m_lag = clampl(sum, longint'(lim_lo), longint'(lim_hi));
        m_out = clampl(lead + m_lag, -(longint'(1) <<< (AW-1)), (longint'(1) <<< (AW-1)) - 1);
    endtask

    task automatic compare(string req);
        n_cmp++;
        if (longint'(freq_out) != m_out || longint'(lag_out) != m_lag) begin
            n_bad++;
            $display("FAIL %s: freq_out=%0d lag_out=%0d expected %0d / %0d",
                     req, freq_out, lag_out, m_out, m_lag);
        end
    endtask

    // inputs already set at negedge; step one edge and compare
    task automatic tick(string req);
        @(posedge clk);
        model_edge();
        @(negedge clk);
        compare(req);
    endtask

    task automatic run(string req, int n, int pe_mag, bit use_fe);
        for (int k = 0; k < n; k++) begin
            upd = 1'b1;
            phase_err = EW'($signed($urandom_range(2*pe_mag, 0)) - pe_mag);
            freq_err  = use_fe ? EW'($signed($urandom_range(400, 0)) - 200) : '0;
            tick(req);
        end
        upd = 1'b0;
    endtask

    initial begin
        while (!done) begin
            @(posedge clk);
            cyc++;
            if (cyc > 100000) begin
                n_bad++;
                $display("FAIL watchdog: cycle=%0d expected < 100000", cyc);
                $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
                $finish;
            end
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        compare("R12");                        // R12 reset state
        rst_n = 1'b1;
        @(negedge clk);
        lim_hi = 24'sd50000; lim_lo = -24'sd50000;
        lead_shift = 5'd1; lag_shift = 5'd4;

        order = 2'd2; run("R3", 40, 2000, 0);   // R3 full filter, shifted gains
        order = 2'd3; run("R1", 10, 2000, 0);   // R1 order 3 as order 2
        phase_err = -12'sd7; lag_shift = 5'd1; upd = 1'b1; tick("R3"); upd = 1'b0;
        order = 2'd1; run("R1", 20, 2000, 0);   // R1 order 1 leaves lag
        order = 2'd0; run("R1", 10, 2000, 0);   // R1 order 0 off
        order = 2'd2; phase_err = 12'sd999;
        for (int k = 0; k < 8; k++) tick("R6"); // R6 no update
        lim_hi = 24'sd300; lim_lo = -24'sd250; lag_shift = 5'd0;
        run("R2", 30, 2047, 0);                 // R2 clamping
        afc_en = 1'b1; afc_shift_trk = 5'd2; afc_shift_acq = 5'd0;
        lim_hi = 24'sd40000; lim_lo = -24'sd40000;
        run("R9", 20, 300, 1);                  // R9 tracking gain
        clr = 1'b1; upd = 1'b1; tick("R11"); clr = 1'b0; upd = 1'b0;

        acquire = 1'b1; sweep_step = 24'd37; afc_en = 1'b0;
        lim_hi = 24'sd200; lim_lo = -24'sd150; flips = 0;
        run("R4", 40, 1500, 0);                 // R4 and R7 sweep, forced first order
        run("R5", 30, 0, 0);                    // R5 reversals
        if (flips < 3) begin n_bad++; $display("FAIL R5: flips=%0d expected >= 3", flips); end
        n_cmp++;
        afc_en = 1'b1; run("R9", 10, 100, 1);   // R9 acquisition gain
        afc_en = 1'b0; order = 2'd2; run("R7", 10, 2000, 0);
        stepped = 1'b1;
        for (int k = 0; k < 40; k++) begin      // R8 stepped sweep
            upd = 1'b1; step_tick = (k % 5 == 4);
            phase_err = 12'sd55; tick("R8");
        end
        upd = 1'b0; step_tick = 1'b0; stepped = 1'b0;
        clr = 1'b1; tick("R11"); clr = 1'b0;
        acquire = 1'b0;

        lim_hi = 24'sh7FFFFF; lim_lo = -24'sh7FFFF0;
        lead_shift = 5'd0; lag_shift = 5'd0; sweep_step = 24'd4000000;
        acquire = 1'b1; upd = 1'b1; phase_err = 12'sd2047;
        for (int k = 0; k < 3; k++) tick("R10");
        acquire = 1'b0; order = 2'd2;
        for (int k = 0; k < 6; k++) tick("R10"); // R10 output saturation
        phase_err = -12'sd2048;
        for (int k = 0; k < 4; k++) tick("R10");
        upd = 1'b0;
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule